// File: doc/BRIEF.md
# Thermal Limit Event Generator

This block watches a sampled 13-bit two's-complement temperature and grades it against three programmable thresholds: an upper alarm bound, a lower alarm bound and a critical bound. Each threshold has its own trip flag, and each flag can be given a selectable hysteresis band that only delays the flag's release. The flags feed an event stage that drives an open-drain alarm pad. The event stage works as a level comparator, as a latched interrupt that software clears, or as a critical-only alarm. Polarity and output enable are programmable.

Temperature words are taken on an update strobe. Threshold words are compared continuously, so rewriting a threshold changes the result on the next clock without a new sample. While the shutdown input is high, the sampled temperature, the trip flags and the internal alarm state all hold. The enable and polarity inputs still act on the pad during shutdown.

Top module: `thermal_event_gen`

## Requirements
- R1: `temp_i` is captured only in a cycle where `temp_vld_i` is 1 and `shdn_i` is 0. Without the strobe, a new value on `temp_i` has no effect on the outputs.
- R2: Each threshold word uses bit 12 as its sign. Its bits 1:0 are treated as zero whatever their value. The threshold is compared as a signed 13-bit value on the same scale as the temperature, whose LSB is 1/16 degree.
- R3: The trip flags are registered and reflect the captured temperature one clock after capture. The critical flag (`trip_crit_o`) trips when temperature >= critical bound. The high flag trips when temperature > high bound. The low flag trips when temperature < low bound.
- R4: `cfg_hyst_i` codes 0, 1, 2 and 3 give bands of 0, 24, 48 and 96 temperature LSBs. A set critical flag releases only when temperature < bound minus band. A set high flag releases when temperature <= bound minus band. A set low flag releases when temperature >= bound plus band. The band never moves the point at which a flag sets.
- R5: In comparator mode (`cfg_intr_mode_i`=0, `cfg_crit_only_i`=0), the alarm is active exactly while any trip flag is set. `evt_clear_i` has no effect in this mode.
- R6: When `cfg_crit_only_i`=1, the alarm follows the critical flag alone. This holds whatever the value of `cfg_intr_mode_i`.
- R7: In interrupt mode (`cfg_intr_mode_i`=1, `cfg_crit_only_i`=0), any change of the high or low flag in either direction latches the alarm. The latch holds until `evt_clear_i` is pulsed. The alarm is also active while the critical flag is set.
- R8: A clear pulse has no effect while the critical flag is set. It also has no effect in comparator mode.
- R9: A change of any threshold word changes the trip flags on the next clock edge, without a temperature strobe.
- R10: `evt_status_o` equals `cfg_out_en_i` AND the alarm state. It does not depend on polarity. `pad_pd_o` equals `evt_status_o` when `cfg_act_high_i`=0 and its inverse when `cfg_act_high_i`=1. So a disabled active-high output grounds the pad.
- R11: While `shdn_i`=1, the captured temperature, the trip flags and the alarm state hold. Clear pulses and threshold writes are ignored. Enable and polarity still act on the outputs.
- R12: While `rst_n` is 0, all trip flags and the alarm state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | 13 | Temperature sample, two's complement, 1/16 degree LSB |
| temp_vld_i | input | 1 | Capture strobe for `temp_i` |
| lim_high_i | input | 13 | Upper alarm threshold, bits 1:0 ignored |
| lim_low_i | input | 13 | Lower alarm threshold, bits 1:0 ignored |
| lim_crit_i | input | 13 | Critical threshold, bits 1:0 ignored |
| cfg_intr_mode_i | input | 1 | 1 selects latched interrupt mode |
| cfg_act_high_i | input | 1 | 1 selects active-high pad polarity |
| cfg_out_en_i | input | 1 | Alarm output enable |
| cfg_crit_only_i | input | 1 | 1 makes the alarm follow the critical flag only |
| cfg_hyst_i | input | 2 | Hysteresis band select |
| evt_clear_i | input | 1 | Clear pulse for the interrupt latch |
| shdn_i | input | 1 | Freeze of sampling and alarm state |
| trip_crit_o | output | 1 | Critical trip flag |
| trip_high_o | output | 1 | High trip flag |
| trip_low_o | output | 1 | Low trip flag |
| evt_status_o | output | 1 | Polarity-independent alarm status |
| pad_pd_o | output | 1 | Pull-down enable for the open-drain alarm pad |

## Verification
The hardest state to reach from the ports is an interrupt latch that is set while the critical flag is also set, followed by a clear pulse that must leave the alarm standing. After that, the critical flag drops and the latch must be re-armed by the same crossing. The directed part of the bench walks the temperature through the window, above the critical bound and back, and pulses clear at each stage. The constrained random part then mixes clear pulses, shutdown, threshold rewrites and mode changes against a cycle model. That mixing covers orders that the directed part does not write out, such as a clear during shutdown or a threshold moving under a held hysteresis band.

// File: rtl/tev_pkg.sv
package tev_pkg;

    // Comparison sense of one trip cell
    typedef enum logic [1:0] {
        K_AT_OR_ABOVE = 2'd0,
        K_ABOVE       = 2'd1,
        K_BELOW       = 2'd2
    } trip_kind_e;

    // Positions in the trip vector
    localparam int IDX_CRIT = 0;
    localparam int IDX_HIGH = 1;
    localparam int IDX_LOW  = 2;
    localparam int N_TRIP   = 3;

    // Smallest non-zero hysteresis band in temperature LSBs
    localparam int HYST_BASE = 24;
    localparam int HYST_W    = 7;

    typedef struct packed {
        logic latch;
        logic asserted;
    } evt_state_t;

    // Band in LSBs for a 2-bit code: 0, base, 2*base, 4*base
    function automatic logic [HYST_W-1:0] hyst_amount(input logic [1:0] code);
        logic [HYST_W-1:0] amt;
        case (code)
            2'd0:    amt = '0;
            2'd1:    amt = HYST_W'(HYST_BASE);
            2'd2:    amt = HYST_W'(HYST_BASE * 2);
            default: amt = HYST_W'(HYST_BASE * 4);
        endcase
        return amt;
    endfunction

endpackage

// File: rtl/tev_temp_hold.sv
module tev_temp_hold #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] temp_i,
    input  logic         vld_i,
    input  logic         hold_i,
    output logic [W-1:0] temp_q_o
);

    logic [W-1:0] temp_d;
    logic [W-1:0] temp_q;

    always_comb begin
        temp_d = temp_q;
        if (vld_i && !hold_i) begin
            temp_d = temp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else begin
            temp_q <= temp_d;
        end
    end

    assign temp_q_o = temp_q;

    // R11: a held block never takes a new sample
    a_r11_temp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(temp_q));

    // R1: a cycle without strobe keeps the stored sample
    a_r1_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(temp_q));

endmodule

// File: rtl/tev_trip_cell.sv
module tev_trip_cell
    import tev_pkg::*;
#(
    parameter int         W    = 13,
    parameter int         Z    = 2,
    parameter trip_kind_e KIND = K_ABOVE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] temp_i,
    input  logic [W-1:0] lim_i,
    input  logic [1:0]   hyst_i,
    input  logic         hold_i,
    output logic         trip_d_o,
    output logic         trip_q_o
);

    // Two guard bits keep bound +/- band from wrapping
    localparam int XW = W + 2;

    logic signed [XW-1:0] t_x;
    logic signed [XW-1:0] l_x;
    logic signed [XW-1:0] h_x;
    logic signed [XW-1:0] rel_x;
    logic                 set_now;
    logic                 release_now;
    logic                 trip_d;
    logic                 trip_q;
    logic                 lim_frac_unused;

    assign lim_frac_unused = ^lim_i[Z-1:0];

    always_comb begin
        t_x = signed'({{2{temp_i[W-1]}}, temp_i});
        l_x = signed'({{2{lim_i[W-1]}}, lim_i[W-1:Z], {Z{1'b0}}});
        h_x = signed'({{(XW-HYST_W){1'b0}}, hyst_amount(hyst_i)});
        case (KIND)
            K_AT_OR_ABOVE: begin
                rel_x       = l_x - h_x;
                set_now     = (t_x >= l_x);
                release_now = (t_x < rel_x);
            end
            K_BELOW: begin
                rel_x       = l_x + h_x;
                set_now     = (t_x < l_x);
                release_now = (t_x >= rel_x);
            end
            default: begin
                rel_x       = l_x - h_x;
                set_now     = (t_x > l_x);
                release_now = (t_x <= rel_x);
            end
        endcase

        trip_d = trip_q;
        if (!hold_i) begin
            if (trip_q) begin
                trip_d = !release_now;
            end else begin
                trip_d = set_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else begin
            trip_q <= trip_d;
        end
    end

    assign trip_d_o = trip_d;
    assign trip_q_o = trip_q;

    // R4: hysteresis never delays the set point
    a_r4_set_point: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && set_now) |=> trip_q);

    // R4: a set flag stays set until the release point is passed
    a_r4_release_point: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && trip_q && !release_now) |=> trip_q);

    // R11: flag frozen while held
    a_r11_trip_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(trip_q));

endmodule

// File: rtl/tev_event_ctrl.sv
module tev_event_ctrl
    import tev_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              intr_mode_i,
    input  logic              crit_only_i,
    input  logic              clear_i,
    input  logic [N_TRIP-1:0] trip_d_i,
    input  logic [N_TRIP-1:0] trip_q_i,
    output logic              asserted_o
);

    evt_state_t st_d;
    evt_state_t st_q;
    logic       window_chg;
    logic       clear_ok;

    always_comb begin
        window_chg = (trip_d_i[IDX_HIGH] ^ trip_q_i[IDX_HIGH]) |
                     (trip_d_i[IDX_LOW]  ^ trip_q_i[IDX_LOW]);
        clear_ok   = clear_i && !trip_q_i[IDX_CRIT];
        st_d       = st_q;
        if (!hold_i) begin
            if (crit_only_i) begin
                st_d.latch    = 1'b0;
                st_d.asserted = trip_d_i[IDX_CRIT];
            end else if (intr_mode_i) begin
                if (window_chg) begin
                    st_d.latch = 1'b1;
                end else if (clear_ok) begin
                    st_d.latch = 1'b0;
                end
                st_d.asserted = st_d.latch | trip_d_i[IDX_CRIT];
            end else begin
                st_d.latch    = 1'b0;
                st_d.asserted = |trip_d_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign asserted_o = st_q.asserted;

    // R8: clear cannot drop a latch while the critical flag is set
    a_r8_crit_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && intr_mode_i && !crit_only_i && trip_q_i[IDX_CRIT] && st_q.latch)
        |=> st_q.latch);

    // R6: critical-only alarm follows the registered critical flag
    a_r6_crit_only_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && crit_only_i) |=> (st_q.asserted == trip_q_i[IDX_CRIT]));

    // R7: a window crossing in interrupt mode latches the alarm
    a_r7_crossing_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && intr_mode_i && !crit_only_i && window_chg)
        |=> (st_q.latch && st_q.asserted));

    // R11: alarm state frozen while held
    a_r11_alarm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(st_q));

endmodule

// File: rtl/thermal_event_gen.sv
module thermal_event_gen
    import tev_pkg::*;
#(
    parameter int TEMP_W    = 13,
    parameter int LIM_ZEROS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_vld_i,
    input  logic [TEMP_W-1:0] lim_high_i,
    input  logic [TEMP_W-1:0] lim_low_i,
    input  logic [TEMP_W-1:0] lim_crit_i,
    input  logic              cfg_intr_mode_i,
    input  logic              cfg_act_high_i,
    input  logic              cfg_out_en_i,
    input  logic              cfg_crit_only_i,
    input  logic [1:0]        cfg_hyst_i,
    input  logic              evt_clear_i,
    input  logic              shdn_i,
    output logic              trip_crit_o,
    output logic              trip_high_o,
    output logic              trip_low_o,
    output logic              evt_status_o,
    output logic              pad_pd_o
);

    logic [TEMP_W-1:0] temp_q;
    logic [TEMP_W-1:0] lims [N_TRIP];
    logic [N_TRIP-1:0] trip_d;
    logic [N_TRIP-1:0] trip_q;
    logic              asserted;

    assign lims[IDX_CRIT] = lim_crit_i;
    assign lims[IDX_HIGH] = lim_high_i;
    assign lims[IDX_LOW]  = lim_low_i;

    tev_temp_hold #(.W(TEMP_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .temp_i   (temp_i),
        .vld_i    (temp_vld_i),
        .hold_i   (shdn_i),
        .temp_q_o (temp_q)
    );

    for (genvar g = 0; g < N_TRIP; g++) begin : g_trip
        tev_trip_cell #(
            .W    (TEMP_W),
            .Z    (LIM_ZEROS),
            .KIND (trip_kind_e'(g))
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .temp_i   (temp_q),
            .lim_i    (lims[g]),
            .hyst_i   (cfg_hyst_i),
            .hold_i   (shdn_i),
            .trip_d_o (trip_d[g]),
            .trip_q_o (trip_q[g])
        );
    end

    tev_event_ctrl u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (shdn_i),
        .intr_mode_i (cfg_intr_mode_i),
        .crit_only_i (cfg_crit_only_i),
        .clear_i     (evt_clear_i),
        .trip_d_i    (trip_d),
        .trip_q_i    (trip_q),
        .asserted_o  (asserted)
    );

    assign trip_crit_o  = trip_q[IDX_CRIT];
    assign trip_high_o  = trip_q[IDX_HIGH];
    assign trip_low_o   = trip_q[IDX_LOW];
    assign evt_status_o = cfg_out_en_i & asserted;
    assign pad_pd_o     = cfg_act_high_i ? !evt_status_o : evt_status_o;

    // R5: in comparator mode the alarm tracks the registered flags
    a_r5_comparator_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_i && !cfg_intr_mode_i && !cfg_crit_only_i)
        |=> (asserted == (trip_crit_o | trip_high_o | trip_low_o)));

endmodule

// File: tb/thermal_event_gen_bench.sv
module thermal_event_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] temp_i = '0;
    logic        temp_vld_i = 1'b0;
    logic [12:0] lim_high_i = 13'h320;
    logic [12:0] lim_low_i  = 13'h190;
    logic [12:0] lim_crit_i = 13'h500;
    logic        cfg_intr_mode_i = 1'b0;
    logic        cfg_act_high_i  = 1'b0;
    logic        cfg_out_en_i    = 1'b1;
    logic        cfg_crit_only_i = 1'b0;
    logic [1:0]  cfg_hyst_i      = 2'd0;
    logic        evt_clear_i     = 1'b0;
    logic        shdn_i          = 1'b0;
    logic        trip_crit_o, trip_high_o, trip_low_o, evt_status_o, pad_pd_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    thermal_event_gen u_thermal_event_gen (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .temp_vld_i(temp_vld_i),
        .lim_high_i(lim_high_i), .lim_low_i(lim_low_i), .lim_crit_i(lim_crit_i),
        .cfg_intr_mode_i(cfg_intr_mode_i), .cfg_act_high_i(cfg_act_high_i),
        .cfg_out_en_i(cfg_out_en_i), .cfg_crit_only_i(cfg_crit_only_i),
        .cfg_hyst_i(cfg_hyst_i), .evt_clear_i(evt_clear_i), .shdn_i(shdn_i),
        .trip_crit_o(trip_crit_o), .trip_high_o(trip_high_o), .trip_low_o(trip_low_o),
        .evt_status_o(evt_status_o), .pad_pd_o(pad_pd_o)
    );

    // ---------------- reference model built from the requirements ----------------
    function automatic int sx13(input logic [12:0] v);
        int r;
        r = int'(v);
        if (v[12]) r = r - 8192;
        return r;
    endfunction

    function automatic int lim_val(input logic [12:0] v);   // R2
        return sx13({v[12:2], 2'b00});
    endfunction

    function automatic int band(input logic [1:0] c);        // R4
        case (c)
            2'd0: return 0;
            2'd1: return 24;
            2'd2: return 48;
            default: return 96;
        endcase
    endfunction

    // kind 0 critical, 1 high, 2 low (R3, R4)
    function automatic bit next_flag(input int kind, input bit q, input int t,
                                     input int l, input int h);
        bit set_c, rel_c;
        case (kind)
            0: begin set_c = (t >= l); rel_c = (t <  l - h); end
            1: begin set_c = (t >  l); rel_c = (t <= l - h); end
            default: begin set_c = (t < l); rel_c = (t >= l + h); end
        endcase
        return q ? !rel_c : set_c;
    endfunction

    int m_temp;
    bit m_crit, m_high, m_low, m_latch, m_ast;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_temp = 0; m_crit = 0; m_high = 0; m_low = 0; m_latch = 0; m_ast = 0;
        end else if (!shdn_i) begin
            bit nc, nh, nl, chg;
            int h;
            h  = band(cfg_hyst_i);
            nc = next_flag(0, m_crit, m_temp, lim_val(lim_crit_i), h);
            nh = next_flag(1, m_high, m_temp, lim_val(lim_high_i), h);
            nl = next_flag(2, m_low,  m_temp, lim_val(lim_low_i),  h);
            chg = (nh != m_high) || (nl != m_low);
            if (cfg_crit_only_i) begin
                m_latch = 0; m_ast = nc;
            end else if (cfg_intr_mode_i) begin
                if (chg) m_latch = 1;
                else if (evt_clear_i && !m_crit) m_latch = 0;
                m_ast = m_latch | nc;
            end else begin
                m_latch = 0; m_ast = nc | nh | nl;
            end
            m_crit = nc; m_high = nh; m_low = nl;
            if (temp_vld_i) m_temp = sx13(temp_i);
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [4:0] outs();
        return {trip_crit_o, trip_high_o, trip_low_o, evt_status_o, pad_pd_o};
    endfunction

    task automatic check5(input string tag, input logic [4:0] exp);
        checks++;
        if (outs() !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b (crit,high,low,status,pad)", tag, outs(), exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_temp(input logic [12:0] t);
        temp_i = t; temp_vld_i = 1'b1;
        tick(1);
        temp_vld_i = 1'b0;
        tick(3);
    endtask

    task automatic pulse_clear();
        evt_clear_i = 1'b1;
        tick(1);
        evt_clear_i = 1'b0;
        tick(3);
    endtask

    task automatic model_check();
        logic [4:0] e;
        bit st;
        st = cfg_out_en_i & m_ast;
        e  = {m_crit, m_high, m_low, st, cfg_act_high_i ? !st : st};
        checks++;
        if (outs()[4:2] !== e[4:2]) begin
            failures++;
            $display("FAIL R3 random trips act=%b exp=%b", outs()[4:2], e[4:2]);
        end
        checks++;
        if (outs()[1:0] !== e[1:0]) begin
            failures++;
            $display("FAIL R10 random event act=%b exp=%b", outs()[1:0], e[1:0]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        tick(4);
        check5("R12 reset state", 5'b00000);
        rst_n = 1'b1;
        tick(3);
        check5("R3 low flag from cleared sample", 5'b00111);

        put_temp(13'h100);  check5("R5 below window", 5'b00111);
        put_temp(13'h320);  check5("R3 equal to high bound", 5'b00000);
        put_temp(13'h321);  check5("R3 above high bound", 5'b01011);
        put_temp(13'h500);  check5("R3 equal to critical", 5'b11011);
        put_temp(13'h4FF);  check5("R3 just below critical", 5'b01011);
        put_temp(13'h190);  check5("R3 equal to low bound", 5'b00000);

        lim_high_i = 13'h323; tick(3);
        put_temp(13'h321);  check5("R2 low bits of bound ignored", 5'b01011);
        lim_high_i = 13'h320;
        put_temp(13'h200);  check5("R2 restore", 5'b00000);
        lim_low_i = 13'h1CE0; tick(3);
        put_temp(13'h1C90); check5("R2 negative below bound", 5'b00111);
        put_temp(13'h1CE1); check5("R2 negative above bound", 5'b00000);
        lim_low_i = 13'h190;

        put_temp(13'h200);  check5("R9 start", 5'b00000);
        lim_high_i = 13'h100; tick(3);
        check5("R9 bound lowered, no strobe", 5'b01011);
        lim_high_i = 13'h320; tick(3);
        check5("R9 bound raised, no strobe", 5'b00000);

        cfg_hyst_i = 2'd1; tick(1);
        put_temp(13'h330);  check5("R4 high set", 5'b01011);
        put_temp(13'h309);  check5("R4 high inside band", 5'b01011);
        put_temp(13'h308);  check5("R4 high released", 5'b00000);
        cfg_hyst_i = 2'd3; tick(1);
        put_temp(13'h321);  check5("R4 set point unmoved", 5'b01011);
        put_temp(13'h2C1);  check5("R4 wide band holds", 5'b01011);
        put_temp(13'h2C0);  check5("R4 wide band release", 5'b00000);
        cfg_hyst_i = 2'd2; tick(1);
        put_temp(13'h18F);  check5("R4 low set", 5'b00111);
        put_temp(13'h1BF);  check5("R4 low inside band", 5'b00111);
        put_temp(13'h1C0);  check5("R4 low released", 5'b00000);
        cfg_hyst_i = 2'd1; tick(1);
        put_temp(13'h500);  check5("R4 critical set", 5'b11011);
        put_temp(13'h4E8);  check5("R4 critical inside band", 5'b11011);
        put_temp(13'h4E7);  check5("R4 critical released", 5'b01011);
        cfg_hyst_i = 2'd0; tick(1);
        put_temp(13'h200);  check5("R4 back in window", 5'b00000);

        cfg_intr_mode_i = 1'b1; tick(3);
        check5("R7 interrupt idle", 5'b00000);
        put_temp(13'h330);  check5("R7 outward crossing", 5'b01011);
        put_temp(13'h200);  check5("R7 latch held after return", 5'b00011);
        pulse_clear();      check5("R7 cleared", 5'b00000);
        put_temp(13'h510);  check5("R7 critical asserted", 5'b11011);
        pulse_clear();      check5("R8 clear blocked by critical", 5'b11011);
        put_temp(13'h200);  check5("R7 return crossing latches", 5'b00011);
        pulse_clear();      check5("R7 cleared again", 5'b00000);
        cfg_intr_mode_i = 1'b0; tick(3);

        put_temp(13'h330);  check5("R5 comparator above", 5'b01011);
        pulse_clear();      check5("R8 clear ignored in comparator", 5'b01011);
        put_temp(13'h200);  check5("R5 comparator in window", 5'b00000);

        cfg_crit_only_i = 1'b1; tick(3);
        put_temp(13'h330);  check5("R6 high alone ignored", 5'b01000);
        put_temp(13'h510);  check5("R6 critical asserts", 5'b11011);
        cfg_intr_mode_i = 1'b1; tick(3);
        check5("R6 precedence over interrupt", 5'b11011);
        put_temp(13'h200);  check5("R6 release without clear", 5'b00000);
        cfg_crit_only_i = 1'b0; cfg_intr_mode_i = 1'b0; tick(3);

        put_temp(13'h330);  check5("R10 active low", 5'b01011);
        cfg_act_high_i = 1'b1; tick(1); check5("R10 active high", 5'b01010);
        cfg_out_en_i = 1'b0;   tick(1); check5("R10 disabled high grounds pad", 5'b01001);
        cfg_act_high_i = 1'b0; tick(1); check5("R10 disabled low releases pad", 5'b01000);
        cfg_out_en_i = 1'b1;   tick(1); check5("R10 re-enabled", 5'b01011);

        shdn_i = 1'b1; tick(1);
        lim_high_i = 13'h300;
        put_temp(13'h200);  check5("R11 frozen during shutdown", 5'b01011);
        cfg_act_high_i = 1'b1; tick(1); check5("R11 polarity acts in shutdown", 5'b01010);
        cfg_act_high_i = 1'b0;
        shdn_i = 1'b0; tick(3);
        check5("R1 sample during shutdown dropped", 5'b01011);
        temp_i = 13'h200; tick(3);
        check5("R1 no strobe no capture", 5'b01011);
        put_temp(13'h200);  check5("R1 strobe captures", 5'b00000);
        lim_high_i = 13'h320; tick(3);

        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            model_check();
            temp_vld_i  = ($urandom % 4) == 0;
            temp_i      = 13'(int'($urandom % 1600) - 300);
            evt_clear_i = ($urandom % 12) == 0;
            if (($urandom % 30) == 0) shdn_i = !shdn_i;
            if (($urandom % 60) == 0) lim_high_i = 13'(int'($urandom % 1200) - 100);
            if (($urandom % 60) == 0) lim_low_i  = 13'(int'($urandom % 1200) - 300);
            if (($urandom % 60) == 0) lim_crit_i = 13'(int'($urandom % 1400));
            if (($urandom % 80) == 0) begin
                cfg_intr_mode_i = 1'($urandom);
                cfg_act_high_i  = 1'($urandom);
                cfg_out_en_i    = ($urandom % 4) != 0;
                cfg_crit_only_i = ($urandom % 4) == 0;
                cfg_hyst_i      = 2'($urandom);
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule